// File: doc/BRIEF.md
# Coherence Home Directory Controller

This block is the home-side directory of a small shared-memory machine with several nodes. For every line homed here it holds a two-bit sharing state and one presence bit per node. Remote nodes send read, read-for-ownership and writeback requests. The home processor bus sends its own write or ownership requests. The controller answers with data or ownership grants. Where other nodes must give up a line, it invalidates them or forwards the request to the owner. It then collects the acknowledgements before it closes the transaction.

One transaction engine serves all lines. While a transaction is open, its line is marked busy. A remote request to that busy line is taken at once and refused with a negative acknowledgement, and the requester retries later. A remote request to any other line is held off with `req_ready` low until the engine is free again.

The engine has six states:
- ST_IDLE takes a new request.
- ST_INVAL sends one invalidation per cycle.
- ST_WAIT_ACK waits for the invalidation acknowledgements.
- ST_FORWARD sends one forwarded request or recall to the owner.
- ST_WAIT_OWNER waits for owner data or for the transfer acknowledgement.
- ST_FINISH writes the final directory entry and sends the closing reply or pulses `local_done`.

The transitions are:
- ST_IDLE to ST_FINISH when an answer can be given at once.
- ST_IDLE to ST_INVAL when there are sharers to invalidate.
- ST_IDLE to ST_FORWARD when the line is Dirty.
- ST_INVAL to ST_WAIT_ACK after the last invalidation is sent.
- ST_WAIT_ACK to ST_FINISH when no acknowledgements are outstanding.
- ST_FORWARD to ST_WAIT_OWNER.
- ST_WAIT_OWNER to ST_FINISH on the awaited response.
- ST_FINISH to ST_IDLE.

Top module: `hdc_home`

## Requirements
- R1: After reset every line is Uncached (state code 0) with no presence bits. `req_ready` and `local_ready` are high, and `msg_valid`, `nak_valid` and `local_done` are low.
- R2: A remote read (req_kind 0; code 3 is handled as a read) to an Uncached or Shared line is answered with a DATA message (msg_kind 0) to the requester. This message appears in the cycle after acceptance. The line becomes Shared with the requester's bit added.
- R3: A remote read-for-ownership (req_kind 1) to an Uncached line, or to a Shared line whose only sharer is the requester, is answered with GRANT (msg_kind 1) in the cycle after acceptance. The line becomes Dirty with only the requester present.
- R4: A read-for-ownership to a Shared line with other sharers sends INV (msg_kind 2) to each other sharer, one per cycle, lowest node first. GRANT follows only after an INV_ACK (rsp_kind 0) from every one of them. Acknowledgements from nodes that were not sent an invalidation are ignored.
- R5: A remote read to a Dirty line sends FWD_READ (msg_kind 3) to the owner, with the requester in `msg_req`. When the owner returns OWNER_DATA (rsp_kind 1), the line becomes Shared with both nodes present.
- R6: A read-for-ownership to a Dirty line sends FWD_RFO (msg_kind 4) to the owner and records the requester as the new owner. The line stays busy until XFER_ACK (rsp_kind 2) arrives from the new owner.
- R7: A writeback (req_kind 2) from the recorded owner of a Dirty line makes the line Uncached. Any writeback is answered with WB_ACK (msg_kind 6). A writeback from a non-owner changes nothing.
- R8: A local request leaves the line Uncached in every case.
  - On an Uncached line, `local_done` pulses in the cycle after acceptance.
  - On a Shared line, every sharer is invalidated and acknowledged before `local_done`.
  - On a Dirty line, RECALL (msg_kind 5) goes to the owner, and `local_done` follows only after the owner returns OWNER_DATA.
- R9: A remote request to a line with an open transaction is accepted in the same cycle. `nak_valid` rises in that cycle with the requester's node and line, and the directory and the open transaction are not affected.
- R10: The local request has priority over a remote request in ST_IDLE. While the engine is busy, `local_ready` is low, and a remote request to another line sees `req_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Remote request present |
| req_ready | output | 1 | Remote request accepted this cycle |
| req_kind | input | 2 | 0 read, 1 read-for-ownership, 2 writeback |
| req_node | input | NW | Requesting node |
| req_line | input | LW | Line index |
| local_valid | input | 1 | Local write/ownership request present |
| local_ready | output | 1 | Local request accepted this cycle |
| local_line | input | LW | Local request line |
| local_done | output | 1 | Local request complete |
| rsp_valid | input | 1 | Node response present (always taken) |
| rsp_kind | input | 2 | 0 INV_ACK, 1 OWNER_DATA, 2 XFER_ACK |
| rsp_node | input | NW | Responding node |
| rsp_line | input | LW | Response line |
| msg_valid | output | 1 | Outgoing message present |
| msg_kind | output | 3 | Message type code |
| msg_node | output | NW | Destination node |
| msg_req | output | NW | Original requester, for forwarded messages |
| msg_line | output | LW | Message line |
| nak_valid | output | 1 | Negative acknowledgement issued |
| nak_node | output | NW | Node being refused |
| nak_line | output | LW | Line being refused |

## Verification
The hardest situation to reach is the window in which a line is busy and the engine is waiting on other nodes. It is most delicate after an ownership forward, where the directory already names the new owner but must still refuse every request.

The stimulus holds back the transfer acknowledgement and the invalidation acknowledgements on purpose. While it waits, it injects a request to the busy line, a request to an unrelated line and an acknowledgement from a node that was never invalidated. It then releases the responses and checks that the following requests see the recorded owner.

// File: rtl/hdc_pkg.sv
package hdc_pkg;

    typedef enum logic [1:0] {
        LN_UNC = 2'd0,
        LN_SHR = 2'd1,
        LN_DRT = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        REQ_READ = 2'd0,
        REQ_RFO  = 2'd1,
        REQ_WB   = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        RSP_INV_ACK    = 2'd0,
        RSP_OWNER_DATA = 2'd1,
        RSP_XFER_ACK   = 2'd2
    } rsp_kind_e;

    typedef enum logic [2:0] {
        MSG_DATA     = 3'd0,
        MSG_GRANT    = 3'd1,
        MSG_INV      = 3'd2,
        MSG_FWD_READ = 3'd3,
        MSG_FWD_RFO  = 3'd4,
        MSG_RECALL   = 3'd5,
        MSG_WB_ACK   = 3'd6
    } msg_kind_e;

endpackage

// File: rtl/hdc_dir_store.sv
module hdc_dir_store
    import hdc_pkg::*;
#(
    parameter int NODES = 4,
    parameter int LINES = 16,
    localparam int LW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LW-1:0]    rd_line,
    output line_st_e         rd_state,
    output logic [NODES-1:0] rd_pres,
    input  logic [LW-1:0]    chk_line,
    output logic             chk_busy,
    input  logic             wr_en,
    input  logic [LW-1:0]    wr_line,
    input  line_st_e         wr_state,
    input  logic [NODES-1:0] wr_pres,
    input  logic             wr_busy
);

    line_st_e         st_q   [LINES];
    logic [NODES-1:0] pres_q [LINES];
    logic [LINES-1:0] busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]   <= LN_UNC;
                pres_q[i] <= '0;
            end
            busy_q <= '0;
        end else if (wr_en) begin
            st_q[wr_line]   <= wr_state;
            pres_q[wr_line] <= wr_pres;
            busy_q[wr_line] <= wr_busy;
        end
    end

    assign rd_state = st_q[rd_line];
    assign rd_pres  = pres_q[rd_line];
    assign chk_busy = busy_q[chk_line];

endmodule

// File: rtl/hdc_first_one.sv
module hdc_first_one #(
    parameter int NODES = 4,
    localparam int NW = $clog2(NODES)
) (
    input  logic [NODES-1:0] mask,
    output logic [NW-1:0]    idx
);

    always_comb begin
        idx = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (mask[i]) idx = NW'(i);
        end
    end

endmodule

// File: rtl/hdc_ack_track.sv
module hdc_ack_track #(
    parameter int NODES = 4,
    localparam int NW = $clog2(NODES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NODES-1:0] load_mask,
    input  logic [NW:0]      load_cnt,
    input  logic             ack_valid,
    input  logic [NW-1:0]    ack_node,
    output logic [NW:0]      left,
    output logic             done
);

    logic [NODES-1:0] exp_q;
    logic [NW:0]      cnt_q;
    logic             hit;

    assign hit = ack_valid && exp_q[ack_node];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            exp_q <= load_mask;
            cnt_q <= load_cnt;
        end else if (hit) begin
            exp_q[ack_node] <= 1'b0;
            cnt_q           <= cnt_q - 1'b1;
        end
    end

    assign left = cnt_q;
    assign done = (cnt_q == '0);

endmodule

// File: rtl/hdc_home.sv
module hdc_home
    import hdc_pkg::*;
#(
    parameter int NODES = 4,
    parameter int LINES = 16,
    localparam int NW = $clog2(NODES),
    localparam int LW = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [NW-1:0] req_node,
    input  logic [LW-1:0] req_line,
    input  logic          local_valid,
    output logic          local_ready,
    input  logic [LW-1:0] local_line,
    output logic          local_done,
    input  logic          rsp_valid,
    input  logic [1:0]    rsp_kind,
    input  logic [NW-1:0] rsp_node,
    input  logic [LW-1:0] rsp_line,
    output logic          msg_valid,
    output logic [2:0]    msg_kind,
    output logic [NW-1:0] msg_node,
    output logic [NW-1:0] msg_req,
    output logic [LW-1:0] msg_line,
    output logic          nak_valid,
    output logic [NW-1:0] nak_node,
    output logic [LW-1:0] nak_line
);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INVAL,
        ST_WAIT_ACK,
        ST_FORWARD,
        ST_WAIT_OWNER,
        ST_FINISH
    } fsm_e;

    fsm_e st_q, st_d;

    // directory access
    logic [LW-1:0]    rd_line;
    line_st_e         rd_state;
    logic [NODES-1:0] rd_pres;
    logic             chk_busy;
    logic             wr_en;
    logic [LW-1:0]    wr_line;
    line_st_e         wr_state;
    logic [NODES-1:0] wr_pres;
    logic             wr_busy;

    // transaction context
    logic [LW-1:0]    cur_line_q;
    logic [NW-1:0]    cur_node_q;
    logic             cur_local_q;
    logic [NW-1:0]    owner_q;
    msg_kind_e        fwd_kind_q;
    rsp_kind_e        wait_kind_q;
    logic [NW-1:0]    wait_node_q;
    logic             fin_msg_q;
    msg_kind_e        fin_kind_q;
    line_st_e         fin_state_q;
    logic [NODES-1:0] fin_pres_q;
    logic [NODES-1:0] pend_q;

    // decision plan
    fsm_e             pl_next;
    logic             pl_fin_msg;
    msg_kind_e        pl_fin_kind;
    line_st_e         pl_fin_state;
    logic [NODES-1:0] pl_fin_pres;
    line_st_e         pl_acc_state;
    logic [NODES-1:0] pl_acc_pres;
    logic [NODES-1:0] pl_targets;
    msg_kind_e        pl_fwd_kind;
    rsp_kind_e        pl_wait_kind;
    logic [NW-1:0]    pl_wait_node;

    logic             idle;
    logic             take_local;
    logic             take_remote;
    logic             take;
    logic             nak_hit;
    logic [NODES-1:0] req_bit;
    logic [NODES-1:0] tgt_mask;
    logic             tgt_any;
    logic [NW-1:0]    owner_idx;
    logic [NW-1:0]    inv_idx;
    logic [NODES-1:0] pend_after;
    logic             ack_in;
    logic [NW:0]      ack_left;
    logic             ack_done;
    logic             owner_rsp;

    assign idle        = (st_q == ST_IDLE);
    assign take_local  = idle && local_valid;
    assign take_remote = idle && !local_valid && req_valid;
    assign take        = take_local || take_remote;
    assign rd_line     = local_valid ? local_line : req_line;

    assign nak_hit     = !idle && req_valid && chk_busy;
    assign req_ready   = (idle && !local_valid) || nak_hit;
    assign local_ready = idle;
    assign nak_valid   = nak_hit;
    assign nak_node    = req_node;
    assign nak_line    = req_line;

    assign req_bit  = {{(NODES-1){1'b0}}, 1'b1} << req_node;
    assign tgt_mask = local_valid ? rd_pres : (rd_pres & ~req_bit);
    assign tgt_any  = |tgt_mask;

    hdc_dir_store #(.NODES(NODES), .LINES(LINES)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_line  (rd_line),
        .rd_state (rd_state),
        .rd_pres  (rd_pres),
        .chk_line (req_line),
        .chk_busy (chk_busy),
        .wr_en    (wr_en),
        .wr_line  (wr_line),
        .wr_state (wr_state),
        .wr_pres  (wr_pres),
        .wr_busy  (wr_busy)
    );

    hdc_first_one #(.NODES(NODES)) owner_pick_i (
        .mask (rd_pres),
        .idx  (owner_idx)
    );

    hdc_first_one #(.NODES(NODES)) inv_pick_i (
        .mask (pend_q),
        .idx  (inv_idx)
    );

    assign pend_after = pend_q & ~({{(NODES-1){1'b0}}, 1'b1} << inv_idx);
    assign ack_in = rsp_valid && (rsp_kind == RSP_INV_ACK) && (rsp_line == cur_line_q)
                    && (st_q == ST_INVAL || st_q == ST_WAIT_ACK);

    hdc_ack_track #(.NODES(NODES)) acks_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .load_mask (pl_targets),
        .load_cnt  ((NW+1)'($countones(pl_targets))),
        .ack_valid (ack_in),
        .ack_node  (rsp_node),
        .left      (ack_left),
        .done      (ack_done)
    );

    assign owner_rsp = rsp_valid && (rsp_kind == wait_kind_q) && (rsp_node == wait_node_q)
                       && (rsp_line == cur_line_q);

    // Decision for a request taken in ST_IDLE
    always_comb begin
        pl_next      = ST_FINISH;
        pl_fin_msg   = 1'b0;
        pl_fin_kind  = MSG_DATA;
        pl_fin_state = rd_state;
        pl_fin_pres  = rd_pres;
        pl_acc_state = rd_state;
        pl_acc_pres  = rd_pres;
        pl_targets   = '0;
        pl_fwd_kind  = MSG_FWD_READ;
        pl_wait_kind = RSP_OWNER_DATA;
        pl_wait_node = owner_idx;
        if (local_valid) begin
            pl_fin_state = LN_UNC;
            pl_fin_pres  = '0;
            unique case (rd_state)
                LN_SHR: begin
                    if (tgt_any) begin
                        pl_next    = ST_INVAL;
                        pl_targets = tgt_mask;
                    end
                end
                LN_DRT: begin
                    pl_next     = ST_FORWARD;
                    pl_fwd_kind = MSG_RECALL;
                end
                default: pl_next = ST_FINISH;
            endcase
        end else begin
            unique case (req_kind)
                REQ_RFO: begin
                    pl_fin_state = LN_DRT;
                    pl_fin_pres  = req_bit;
                    if (rd_state == LN_DRT) begin
                        pl_next      = ST_FORWARD;
                        pl_fwd_kind  = MSG_FWD_RFO;
                        pl_acc_state = LN_DRT;
                        pl_acc_pres  = req_bit;
                        pl_wait_kind = RSP_XFER_ACK;
                        pl_wait_node = req_node;
                    end else begin
                        pl_fin_msg  = 1'b1;
                        pl_fin_kind = MSG_GRANT;
                        if (tgt_any) begin
                            pl_next    = ST_INVAL;
                            pl_targets = tgt_mask;
                        end
                    end
                end
                REQ_WB: begin
                    pl_fin_msg  = 1'b1;
                    pl_fin_kind = MSG_WB_ACK;
                    if (rd_state == LN_DRT && rd_pres[req_node]) begin
                        pl_fin_state = LN_UNC;
                        pl_fin_pres  = '0;
                    end
                end
                default: begin
                    pl_fin_state = LN_SHR;
                    pl_fin_pres  = rd_pres | req_bit;
                    if (rd_state == LN_DRT) begin
                        pl_next     = ST_FORWARD;
                        pl_fwd_kind = MSG_FWD_READ;
                    end else begin
                        pl_fin_msg  = 1'b1;
                        pl_fin_kind = MSG_DATA;
                    end
                end
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:       if (take) st_d = pl_next;
            ST_INVAL:      if (pend_after == '0) st_d = ST_WAIT_ACK;
            ST_WAIT_ACK:   if (ack_done) st_d = ST_FINISH;
            ST_FORWARD:    st_d = ST_WAIT_OWNER;
            ST_WAIT_OWNER: if (owner_rsp) st_d = ST_FINISH;
            ST_FINISH:     st_d = ST_IDLE;
            default:       st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Transaction context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_line_q  <= '0;
            cur_node_q  <= '0;
            cur_local_q <= 1'b0;
            owner_q     <= '0;
            fwd_kind_q  <= MSG_FWD_READ;
            wait_kind_q <= RSP_OWNER_DATA;
            wait_node_q <= '0;
            fin_msg_q   <= 1'b0;
            fin_kind_q  <= MSG_DATA;
            fin_state_q <= LN_UNC;
            fin_pres_q  <= '0;
            pend_q      <= '0;
        end else if (take) begin
            cur_line_q  <= rd_line;
            cur_node_q  <= req_node;
            cur_local_q <= take_local;
            owner_q     <= owner_idx;
            fwd_kind_q  <= pl_fwd_kind;
            wait_kind_q <= pl_wait_kind;
            wait_node_q <= pl_wait_node;
            fin_msg_q   <= pl_fin_msg;
            fin_kind_q  <= pl_fin_kind;
            fin_state_q <= pl_fin_state;
            fin_pres_q  <= pl_fin_pres;
            pend_q      <= pl_targets;
        end else if (st_q == ST_INVAL) begin
            pend_q <= pend_after;
        end
    end

    // Directory write port
    always_comb begin
        wr_en    = 1'b0;
        wr_line  = cur_line_q;
        wr_state = fin_state_q;
        wr_pres  = fin_pres_q;
        wr_busy  = 1'b0;
        if (take) begin
            wr_en    = 1'b1;
            wr_line  = rd_line;
            wr_state = pl_acc_state;
            wr_pres  = pl_acc_pres;
            wr_busy  = 1'b1;
        end else if (st_q == ST_FINISH) begin
            wr_en = 1'b1;
        end
    end

    // Outputs by state
    always_comb begin
        msg_valid  = 1'b0;
        msg_kind   = MSG_DATA;
        msg_node   = cur_node_q;
        msg_req    = cur_node_q;
        msg_line   = cur_line_q;
        local_done = 1'b0;
        unique case (st_q)
            ST_INVAL: begin
                msg_valid = 1'b1;
                msg_kind  = MSG_INV;
                msg_node  = inv_idx;
            end
            ST_FORWARD: begin
                msg_valid = 1'b1;
                msg_kind  = fwd_kind_q;
                msg_node  = owner_q;
            end
            ST_FINISH: begin
                msg_valid  = fin_msg_q;
                msg_kind   = fin_kind_q;
                local_done = cur_local_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/hdc_home_chk.sv
module hdc_home_chk #(
    parameter int NW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          msg_valid,
    input logic [2:0]    msg_kind,
    input logic [NW-1:0] msg_node,
    input logic          nak_valid,
    input logic          local_valid,
    input logic          local_ready,
    input logic          req_valid,
    input logic          req_ready,
    input logic          local_done,
    input logic [NW:0]   ack_left
);

    // R4
    grant_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 3'd1) |-> (ack_left == '0));

    // R4
    inv_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 3'd2) |=>
            !(msg_valid && msg_kind == 3'd2 && msg_node == $past(msg_node)));

    // R9
    nak_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nak_valid |-> !local_ready);

    // R10
    single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (local_valid && local_ready) |-> !(req_valid && req_ready));

    // R8
    done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        local_done |=> local_ready);

endmodule

bind hdc_home hdc_home_chk #(.NW(NW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_valid   (msg_valid),
    .msg_kind    (msg_kind),
    .msg_node    (msg_node),
    .nak_valid   (nak_valid),
    .local_valid (local_valid),
    .local_ready (local_ready),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .local_done  (local_done),
    .ack_left    (ack_left)
);

// File: tb/hdc_home_tb.sv
module hdc_home_tb_top;

    localparam int NODES = 4;
    localparam int LINES = 16;
    localparam int NW = 2;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [NW-1:0] req_node = '0;
    logic [LW-1:0] req_line = '0;
    logic          local_valid = 1'b0;
    logic          local_ready;
    logic [LW-1:0] local_line = '0;
    logic          local_done;
    logic          rsp_valid = 1'b0;
    logic [1:0]    rsp_kind = '0;
    logic [NW-1:0] rsp_node = '0;
    logic [LW-1:0] rsp_line = '0;
    logic          msg_valid;
    logic [2:0]    msg_kind;
    logic [NW-1:0] msg_node;
    logic [NW-1:0] msg_req;
    logic [LW-1:0] msg_line;
    logic          nak_valid;
    logic [NW-1:0] nak_node;
    logic [LW-1:0] nak_line;

    always #10 clk = ~clk;

    hdc_home #(.NODES(NODES), .LINES(LINES)) dut_i (.*);

    int checks = 0;
    int errors = 0;

    // {req_kind, node, line, expected msg kind, expected msg node}
    localparam logic [12:0] VEC [0:7] = '{
        {2'd0, 2'd1, 4'd0, 3'd0, 2'd1},  // R2 read U
        {2'd0, 2'd2, 4'd0, 3'd0, 2'd2},  // R2 read S
        {2'd2, 2'd3, 4'd1, 3'd6, 2'd3},  // R7 stale writeback
        {2'd1, 2'd0, 4'd1, 3'd1, 2'd0},  // R3 rfo U
        {2'd2, 2'd0, 4'd1, 3'd6, 2'd0},  // R7 owner writeback
        {2'd1, 2'd2, 4'd1, 3'd1, 2'd2},  // R3/R7 line back to U
        {2'd3, 2'd3, 4'd2, 3'd0, 2'd3},  // R2 code 3 as read
        {2'd1, 2'd3, 4'd2, 3'd1, 2'd3}   // R3 sole sharer upgrade
    };

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic send_req(input logic [1:0] k, input logic [NW-1:0] n, input logic [LW-1:0] l);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_node = n; req_line = l;
        #1;
        while (!req_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_local(input logic [LW-1:0] l);
        @(negedge clk);
        local_valid = 1'b1; local_line = l;
        #1;
        while (!local_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk);
        @(negedge clk);
        local_valid = 1'b0;
    endtask

    task automatic send_rsp(input logic [1:0] k, input logic [NW-1:0] n, input logic [LW-1:0] l);
        rsp_valid = 1'b1; rsp_kind = k; rsp_node = n; rsp_line = l;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic get_msg(output int k, output int n, output int r);
        int t = 0;
        #1;
        while (!msg_valid && t < 20) begin
            @(negedge clk); #1; t++;
        end
        k = msg_valid ? int'(msg_kind) : -1;
        n = int'(msg_node);
        r = int'(msg_req);
        @(negedge clk);
    endtask

    task automatic get_done(output int seen);
        int t = 0;
        #1;
        while (!local_done && t < 20) begin
            @(negedge clk); #1; t++;
        end
        seen = int'(local_done);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int k, n, r, d, cnt;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 req_ready", int'(req_ready), 1);
        chk("R1 local_ready", int'(local_ready), 1);
        chk("R1 msg_valid", int'(msg_valid), 0);
        chk("R1 nak_valid", int'(nak_valid), 0);
        chk("R1 local_done", int'(local_done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: fresh line L9 is Uncached, so ownership is granted directly
        send_req(2'd1, 2'd1, 4'd9);
        get_msg(k, n, r);
        chk("R1 untouched line grant", k, 1);

        // table walk
        for (int i = 0; i < 8; i++) begin
            send_req(VEC[i][12:11], VEC[i][10:9], VEC[i][8:5]);
            get_msg(k, n, r);
            chk($sformatf("R2/R3/R7 vec %0d kind", i), k, int'(VEC[i][4:2]));
            chk($sformatf("R2/R3/R7 vec %0d node", i), n, int'(VEC[i][1:0]));
        end

        // R4: line 3 shared by 0,1,2; node 1 upgrades
        for (int i = 0; i < 3; i++) begin
            send_req(2'd0, NW'(i), 4'd3);
            get_msg(k, n, r);
            chk("R2 build sharers", k, 0);
        end
        send_req(2'd1, 2'd1, 4'd3);
        get_msg(k, n, r);
        chk("R4 first inv kind", k, 2);
        chk("R4 first inv node", n, 0);
        get_msg(k, n, r);
        chk("R4 second inv kind", k, 2);
        chk("R4 second inv node", n, 2);
        send_rsp(2'd0, 2'd3, 4'd3);   // not a target
        send_rsp(2'd0, 2'd0, 4'd3);
        // R9: same line while busy
        req_valid = 1'b1; req_kind = 2'd0; req_node = 2'd3; req_line = 4'd3;
        #1;
        chk("R9 nak_valid", int'(nak_valid), 1);
        chk("R9 nak_node", int'(nak_node), 3);
        chk("R9 nak_line", int'(nak_line), 3);
        chk("R9 ready on busy line", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 0;
        for (int i = 0; i < 4; i++) begin
            #1; if (msg_valid) cnt++;
            @(negedge clk);
        end
        chk("R4 no grant before all acks", cnt, 0);
        send_rsp(2'd0, 2'd2, 4'd3);
        get_msg(k, n, r);
        chk("R4 grant kind", k, 1);
        chk("R4 grant node", n, 1);

        // R5: line 1 dirty at node 2, node 0 reads
        send_req(2'd0, 2'd0, 4'd1);
        get_msg(k, n, r);
        chk("R5 fwd read kind", k, 3);
        chk("R5 fwd read owner", n, 2);
        chk("R5 fwd read requester", r, 0);
        send_rsp(2'd1, 2'd2, 4'd1);
        send_req(2'd1, 2'd3, 4'd1);
        get_msg(k, n, r);
        chk("R5 sharer 0 invalidated", n, 0);
        get_msg(k, n, r);
        chk("R5 sharer 2 invalidated", n, 2);
        send_rsp(2'd0, 2'd0, 4'd1);
        send_rsp(2'd0, 2'd2, 4'd1);
        get_msg(k, n, r);
        chk("R4 grant after both acks", k, 1);
        chk("R4 grant to node 3", n, 3);

        // R6: dirty at 3, node 0 takes ownership
        send_req(2'd1, 2'd0, 4'd1);
        get_msg(k, n, r);
        chk("R6 fwd rfo kind", k, 4);
        chk("R6 fwd rfo owner", n, 3);
        chk("R6 fwd rfo requester", r, 0);
        req_valid = 1'b1; req_kind = 2'd0; req_node = 2'd1; req_line = 4'd1;
        #1;
        chk("R6 busy until xfer ack", int'(nak_valid), 1);
        @(negedge clk);
        req_line = 4'd7;
        #1;
        chk("R10 other line stalled", int'(req_ready), 0);
        chk("R10 local_ready low when busy", int'(local_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        send_rsp(2'd2, 2'd0, 4'd1);
        send_req(2'd0, 2'd2, 4'd1);
        get_msg(k, n, r);
        chk("R6 new owner recorded kind", k, 3);
        chk("R6 new owner recorded node", n, 0);
        send_rsp(2'd1, 2'd0, 4'd1);

        // R8: local on shared {0,2}
        send_local(4'd1);
        get_msg(k, n, r);
        chk("R8 local inv node 0", n, 0);
        get_msg(k, n, r);
        chk("R8 local inv node 2", n, 2);
        send_rsp(2'd0, 2'd0, 4'd1);
        send_rsp(2'd0, 2'd2, 4'd1);
        get_done(d);
        chk("R8 local done after acks", d, 1);
        send_req(2'd1, 2'd1, 4'd1);
        get_msg(k, n, r);
        chk("R8 line uncached after local", k, 1);

        // R8: local on dirty owner 1
        send_local(4'd1);
        get_msg(k, n, r);
        chk("R8 recall kind", k, 5);
        chk("R8 recall node", n, 1);
        #1;
        chk("R8 no done before owner data", int'(local_done), 0);
        send_rsp(2'd1, 2'd1, 4'd1);
        get_done(d);
        chk("R8 done after recall", d, 1);
        send_req(2'd0, 2'd3, 4'd1);
        get_msg(k, n, r);
        chk("R8 read after recall is data", k, 0);

        // R8: local on uncached line, R10 priority
        @(negedge clk);
        local_valid = 1'b1; local_line = 4'd6;
        req_valid = 1'b1; req_kind = 2'd0; req_node = 2'd1; req_line = 4'd7;
        #1;
        chk("R10 local priority local_ready", int'(local_ready), 1);
        chk("R10 local priority req_ready", int'(req_ready), 0);
        @(negedge clk);
        local_valid = 1'b0;
        #1;
        chk("R8 uncached local done next cycle", int'(local_done), 1);
        chk("R8 uncached local no message", int'(msg_valid), 0);
        while (!req_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        get_msg(k, n, r);
        chk("R10 held request served kind", k, 0);
        chk("R10 held request served node", n, 1);

        summary();
    end

endmodule